// File: doc/BRIEF.md
# Multi-format serial audio port

This block connects a two-wire-clocked serial audio bus to parallel stereo sample words, in both directions at once. The bus has a bit clock, a word-select line that tells the left channel from the right, and one data line in each direction. The bit clock and word select arrive from outside and are sampled by the block's own system clock. The receive side turns the incoming bit stream into a 24-bit left word and a 24-bit right word. The transmit side turns a stored left/right pair into an outgoing bit stream that fits the same frame.

A single two-bit format setting selects the framing for both directions. The choices are I2S with up to 24 data bits per channel, or right-justified framing with 16, 20 or 24 data bits, where the last bit before each word-select change is the LSB. All parallel words are MSB-aligned in a 24-bit field. Word select may only change together with a falling bit clock edge. A change seen on a rising edge marks a broken frame. That frame is dropped and a sticky error flag is raised.

Top module: `aud_serial_port`

## Requirements
- R1: The format setting uses the codes 0 = I2S, 1 = right-justified 16-bit, 2 = right-justified 20-bit and 3 = right-justified 24-bit. It is loaded from `fmt_wdata` when `fmt_we` is high and holds otherwise. Reset selects I2S and drives `rx_valid`, `frame_err`, `tx_load` and `sd_out` low.
- R2: In I2S format the receiver takes the first bit sampled one bit-clock period after a word-select change as the MSB. It places the bits MSB-first from bit 23 of the parallel word downward. Word select low is the left channel and high is the right channel.
- R3: In I2S format, bits after the 24th of a channel are ignored. Words shorter than 24 bits therefore come out MSB-aligned, with zeros below when the sender drives zeros.
- R4: In a right-justified format of length L, the bit sampled on the last rising edge before a word-select change is the LSB. The L bits ending there appear in bits 23 down to 24-L of the parallel word, and the lower bits are zero. Bits received earlier in the channel are ignored.
- R5: When a right-channel word completes, following a left word of the same frame, `rx_left` and `rx_right` are updated and `rx_valid` is high for exactly one system-clock cycle.
- R6: In I2S format the transmitter drives bit 23-k of the channel word on the falling edge k+1 after the word-select change, for k from 0 to 23. In every other slot it drives 0.
- R7: In a right-justified format of length L, the transmitter drives the LSB on the last falling edge before the next word-select change. It places the channel length measured in the previous half-frame so that this holds. Earlier slots carry bit 23 of the word as sign extension.
- R8: A pair written with `tx_wr` is taken up at the next falling-edge change of word select to low, and `tx_load` pulses for one cycle. Without a new write, the previous pair is sent again and `tx_load` stays low.
- R9: A word-select change that coincides with a rising bit-clock edge sets `frame_err`, which stays set until reset. The stereo pair of that frame is not presented.
- R10: Receive and transmit always use the same format setting. A format change alters the framing of both.
- R11: `sd_out` changes only after a falling bit-clock edge, and input data is taken only at rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bck_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Word select, low = left, high = right |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| fmt_we | input | 1 | Format write strobe |
| fmt_wdata | input | 2 | Format code (see R1) |
| tx_left | input | 24 | Left word to transmit, MSB-aligned |
| tx_right | input | 24 | Right word to transmit, MSB-aligned |
| tx_wr | input | 1 | Stores tx_left/tx_right as the next pair |
| tx_load | output | 1 | Pulse: pending pair taken into the serializer |
| rx_left | output | 24 | Received left word, MSB-aligned |
| rx_right | output | 24 | Received right word, MSB-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |
| frame_err | output | 1 | Sticky word-select timing error |

## Verification
The bench fills every slot that must be ignored with ones: the slots past the 24th bit in I2S and the leading slots in right-justified mode. A receiver that counted the wrong slots or failed to mask would then show stray high bits in its low-order output. Each format is run in turn. This catches a design whose receiver and transmitter drift apart, and a design that places the LSB one slot off, since that shifts every transmitted frame and puts the wrong sign bits in the leading slots. A frame with its word-select change moved onto a rising edge must raise the sticky flag and lose exactly that pair. A design that still emitted the pair, or that dropped the frame after it as well, shows the wrong pair count. A frame sent with no new write must repeat the last pair without a load pulse.

// File: rtl/aud_pkg.sv
// Shared types for the serial audio port.
// Holds the format code and the data-word length that each format implies.
package aud_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_RJ16 = 2'd1,
        FMT_RJ20 = 2'd2,
        FMT_RJ24 = 2'd3
    } aud_fmt_e;

    // Number of valid data bits carried by a format (I2S carries up to 24)
    function automatic int fmt_len(aud_fmt_e f);
        case (f)
            FMT_RJ16: return 16;
            FMT_RJ20: return 20;
            default:  return 24;
        endcase
    endfunction

endpackage

// File: rtl/aud_edge_sync.sv
// Brings bit clock, word select and serial data into the system clock domain.
// All three go through the same number of stages, so their relative timing is
// kept. From the synchronized bit clock it derives one-cycle rise and fall
// strikes, and it flags any cycle in which word select changed.
// Assumes the system clock is at least four times faster than the bit clock.
module aud_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic bck_rise,
    output logic bck_fall,
    output logic ws_lvl,
    output logic ws_edge,
    output logic sd_lvl
);
    localparam int LAST = STAGES - 1;
    // bit order within each stage: {sd, ws, bck}; idle reset value is ws=1, bck=1
    localparam logic [2:0] IDLE = 3'b011;

    logic [2:0] stg [STAGES];
    logic       bck_q;
    logic       ws_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first stage samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= IDLE;
                    else        stg[g] <= {sd_in, ws_in, bck_in};
                end
            end else begin : g_next
                // later stages pass the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= IDLE;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    // one-cycle history of the synchronized clock and word select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_q <= 1'b1;
            ws_q  <= 1'b1;
        end else begin
            bck_q <= stg[LAST][0];
            ws_q  <= stg[LAST][1];
        end
    end

    // edge strikes and synchronized levels
    always_comb begin
        bck_rise = stg[LAST][0] & ~bck_q;
        bck_fall = ~stg[LAST][0] & bck_q;
        ws_lvl   = stg[LAST][1];
        ws_edge  = stg[LAST][1] ^ ws_q;
        sd_lvl   = stg[LAST][2];
    end

endmodule

// File: rtl/aud_rx.sv
// Deserializer. It samples serial data on each rising bit-clock strike and
// assembles one channel word per word-select half-frame, for either I2S or
// right-justified framing. A stereo pair is presented once its right word
// completes. A word-select change seen on a rising strike (ws_err) raises a
// sticky error and discards the pair of that frame.
// Assumes strikes come from aud_edge_sync, so ws_lvl is stable between falls.
module aud_rx
    import aud_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  aud_fmt_e          fmt,
    input  logic              bck_rise,
    input  logic              ws_lvl,
    input  logic              sd_lvl,
    input  logic              ws_err,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid,
    output logic              frame_err
);
    logic [WORD_W-1:0] shreg;      // last WORD_W bits, newest at bit 0
    logic [WORD_W-1:0] cap;        // I2S word, MSB-first placement
    logic [WORD_W-1:0] cap_nx;
    logic [WORD_W-1:0] rj_word;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] left_hold;
    logic [CNT_W-1:0]  idx;        // I2S bit position within the channel
    logic              ws_prev;    // word select seen at the previous rise
    logic              armed;      // a first word-select change has been seen
    logic              left_ok;    // a clean left word is waiting for its right
    logic              bad;        // current frame saw a timing error
    logic              chg;
    logic              done;

    // word assembly for both framings; the format picks which is used
    always_comb begin
        chg    = (ws_lvl != ws_prev);
        cap_nx = cap;
        if (int'(idx) < WORD_W) cap_nx[WORD_W-1-int'(idx)] = sd_lvl;
        rj_word = shreg << (WORD_W - fmt_len(fmt));
        word    = (fmt == FMT_I2S) ? cap_nx : rj_word;
        done    = bck_rise && chg && armed;
    end

    // bit capture on every rising strike
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            cap     <= '0;
            idx     <= '0;
            ws_prev <= 1'b1;
            armed   <= 1'b0;
        end else if (bck_rise) begin
            ws_prev <= ws_lvl;
            shreg   <= {shreg[WORD_W-2:0], sd_lvl};
            armed   <= armed | chg;
            if (chg) begin
                cap <= '0;
                idx <= '0;
            end else begin
                cap <= cap_nx;
                if (int'(idx) < WORD_W) idx <= idx + 1'b1;
            end
        end
    end

    // pair assembly, presentation strobe and error tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            bad       <= 1'b0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_err <= frame_err | ws_err;
            if (done && !ws_prev) begin
                left_hold <= word;
                left_ok   <= !(bad || ws_err);
                bad       <= bad | ws_err;
            end else if (done) begin
                if (left_ok && !bad && !ws_err) begin
                    rx_valid <= 1'b1;
                    rx_left  <= left_hold;
                    rx_right <= word;
                end
                left_ok <= 1'b0;
                bad     <= ws_err;
            end else begin
                bad <= bad | ws_err;
            end
        end
    end

    // R5
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R11
    rx_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bck_rise));
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
    // R9
    err_drops_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ws_err |=> !rx_valid);

endmodule

// File: rtl/aud_tx.sv
// Serializer. It launches one bit on each falling bit-clock strike. For I2S
// it counts slots forward from the word-select change. For right-justified
// framing it counts backward from the expected end of the channel, using the
// slot count of the previous half-frame, and fills leading slots with the sign.
// A pending pair is taken at the change of word select to low.
// Assumes word select only changes on falling strikes.
module aud_tx
    import aud_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int CNT_W    = 6,
    parameter int SLOT_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  aud_fmt_e          fmt,
    input  logic              bck_fall,
    input  logic              ws_lvl,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    input  logic              tx_wr,
    output logic              sd_out,
    output logic              tx_load
);
    localparam int CNT_TOP = (1 << CNT_W) - 2;

    logic              ws_tx;      // word select seen at the previous fall
    logic [CNT_W-1:0]  cnt;        // falls since the last change
    logic [CNT_W-1:0]  nprev;      // slot count of the previous half-frame
    logic [WORD_W-1:0] cur_l, cur_r, pend_l, pend_r, new_l, new_r, w;
    logic              pend;
    logic              chg, take, bit_nx;
    int                len, k, m, per, p;

    // next output bit for the coming fall
    always_comb begin
        chg   = (ws_lvl != ws_tx);
        take  = bck_fall && chg && !ws_lvl && pend;
        new_l = take ? pend_l : cur_l;
        new_r = take ? pend_r : cur_r;
        len   = fmt_len(fmt);
        k     = int'(cnt);
        m     = chg ? 0 : int'(cnt) + 1;
        per   = chg ? int'(cnt) + 1 : int'(nprev);
        p     = per - 1 - m;
        if (fmt == FMT_I2S) begin
            w      = ws_tx ? cur_r : cur_l;
            bit_nx = (k < WORD_W) ? w[WORD_W-1-k] : 1'b0;
        end else begin
            w = ws_lvl ? new_r : new_l;
            if (p < 0)           bit_nx = 1'b0;
            else if (p >= len)   bit_nx = w[WORD_W-1];
            else                 bit_nx = w[WORD_W-len+p];
        end
    end

    // slot counting and bit launch on falling strikes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_tx  <= 1'b1;
            cnt    <= '0;
            nprev  <= CNT_W'(SLOT_RST);
            sd_out <= 1'b0;
        end else if (bck_fall) begin
            ws_tx  <= ws_lvl;
            sd_out <= bit_nx;
            if (chg) begin
                cnt   <= '0;
                nprev <= cnt + 1'b1;
            end else if (int'(cnt) < CNT_TOP) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // pending pair store and hand-over to the serializer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_l   <= '0;
            cur_r   <= '0;
            pend_l  <= '0;
            pend_r  <= '0;
            pend    <= 1'b0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= take;
            if (take) begin
                cur_l <= pend_l;
                cur_r <= pend_r;
                pend  <= 1'b0;
            end
            if (tx_wr) begin
                pend_l <= tx_left;
                pend_r <= tx_right;
                pend   <= 1'b1;
            end
        end
    end

    // R11
    sd_out_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> $past(bck_fall));
    // R8
    tx_load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> ($past(bck_fall) && !$past(ws_lvl)));

endmodule

// File: rtl/aud_serial_port.sv
// Top of the serial audio port. It holds the shared format setting,
// synchronizes the serial bus, and drives the receive and transmit engines
// from the same strikes and the same format, so both directions always frame
// alike. A word-select change landing on a rising strike is reported to the
// receiver as a timing error.
// Assumes an asynchronous bit clock well below the system clock rate.
module aud_serial_port
    import aud_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2,
    parameter int SLOT_RST    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_in,
    input  logic              ws_in,
    input  logic              sd_in,
    output logic              sd_out,
    input  logic              fmt_we,
    input  logic [1:0]        fmt_wdata,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    input  logic              tx_wr,
    output logic              tx_load,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid,
    output logic              frame_err
);
    aud_fmt_e fmt;
    logic     bck_rise, bck_fall, ws_lvl, ws_edge, sd_lvl, ws_err;

    // shared format setting
    always_ff @(posedge clk) begin
        if (!rst_n)      fmt <= FMT_I2S;
        else if (fmt_we) fmt <= aud_fmt_e'(fmt_wdata);
    end

    // word select moving together with a rising strike is a timing fault
    always_comb ws_err = bck_rise & ws_edge;

    aud_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_in   (bck_in),
        .ws_in    (ws_in),
        .sd_in    (sd_in),
        .bck_rise (bck_rise),
        .bck_fall (bck_fall),
        .ws_lvl   (ws_lvl),
        .ws_edge  (ws_edge),
        .sd_lvl   (sd_lvl)
    );

    aud_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .bck_rise  (bck_rise),
        .ws_lvl    (ws_lvl),
        .sd_lvl    (sd_lvl),
        .ws_err    (ws_err),
        .rx_left   (rx_left),
        .rx_right  (rx_right),
        .rx_valid  (rx_valid),
        .frame_err (frame_err)
    );

    aud_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W), .SLOT_RST(SLOT_RST)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (fmt),
        .bck_fall (bck_fall),
        .ws_lvl   (ws_lvl),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .tx_wr    (tx_wr),
        .sd_out   (sd_out),
        .tx_load  (tx_load)
    );

    // R1
    fmt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (fmt == FMT_I2S));
    // R1
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fmt_we)) |-> $stable(fmt));

endmodule

// File: tb/sim_aud_serial_port.sv
module sim_aud_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;     // system clocks per bit-clock half period
    localparam int SLOTS      = 32;    // bit-clock periods per channel

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck_in = 1'b1, ws_in = 1'b1, sd_in = 1'b0;
    logic        sd_out;
    logic        fmt_we = 1'b0;
    logic [1:0]  fmt_wdata = 2'd0;
    logic [23:0] tx_left = '0, tx_right = '0;
    logic        tx_wr = 1'b0;
    logic        tx_load;
    logic [23:0] rx_left, rx_right;
    logic        rx_valid, frame_err;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [1:0] cur_fmt = 2'd0;

    logic [23:0] got_l [64], got_r [64], exp_l [64], exp_r [64];
    int got_n = 0, exp_n = 0, seen = 0, loads = 0;
    logic [23:0] last_tl = '0, last_tr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .bck_in(bck_in), .ws_in(ws_in), .sd_in(sd_in),
        .sd_out(sd_out), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
        .tx_left(tx_left), .tx_right(tx_right), .tx_wr(tx_wr), .tx_load(tx_load),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
        .frame_err(frame_err)
    );

    // record presented pairs and load strobes
    always @(posedge clk) begin
        if (rst_n && rx_valid && got_n < 64) begin
            got_l[got_n] = rx_left;
            got_r[got_n] = rx_right;
            got_n++;
        end
        if (rst_n && tx_load) loads++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int blen(input logic [1:0] f);
        return (f == 2'd1) ? 16 : (f == 2'd2) ? 20 : 24;
    endfunction

    // bit placed on the bus for slot s (0 = slot of the word-select change)
    function automatic logic slot_bit(input logic [1:0] f, input logic [23:0] v,
                                      input int s, input logic [31:0] junk);
        int p, l;
        if (f == 2'd0) return (s >= 1 && s <= 24) ? v[24-s] : junk[s];
        p = SLOTS - 1 - s;
        l = blen(f);
        return (p < l) ? v[24-l+p] : junk[s];
    endfunction

    // bit the transmitter must send in slot s
    function automatic logic tx_bit(input logic [1:0] f, input logic [23:0] v, input int s);
        int p, l;
        if (f == 2'd0) return (s >= 1 && s <= 24) ? v[24-s] : 1'b0;
        p = SLOTS - 1 - s;
        l = blen(f);
        return (p < l) ? v[24-l+p] : v[23];
    endfunction

    task automatic set_fmt(input logic [1:0] f);
        @(negedge clk);
        fmt_wdata = f; fmt_we = 1'b1;
        @(negedge clk);
        fmt_we = 1'b0;
        cur_fmt = f;
    endtask

    task automatic write_tx(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        tx_left = l; tx_right = r; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        last_tl = l; last_tr = r;
    endtask

    // one stereo frame; err moves the right-channel word-select change onto a rise
    task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                              input logic [31:0] junk, input bit err,
                              input bit good, input bit chk_tx, input string req);
        logic [63:0] gotb, expb;
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < SLOTS; s++) begin
                bck_in = 1'b0;
                ws_in  = (err && c == 1 && s == 0) ? 1'b0 : (c == 1);
                sd_in  = slot_bit(cur_fmt, (c == 1) ? r : l, s, junk);
                repeat (HALF) @(negedge clk);
                gotb[c*SLOTS+s] = sd_out;
                expb[c*SLOTS+s] = tx_bit(cur_fmt, (c == 1) ? last_tr : last_tl, s);
                bck_in = 1'b1;
                if (err && c == 1 && s == 0) ws_in = 1'b1;
                repeat (HALF) @(negedge clk);
            end
        end
        if (good && exp_n < 64) begin
            exp_l[exp_n] = l; exp_r[exp_n] = r; exp_n++;
        end
        if (chk_tx) chk(gotb == expb, req, "tx frame bits", gotb, expb);
    endtask

    task automatic flush();
        send_frame(24'h0, 24'h0, 32'h0, 1'b0, 1'b1, 1'b0, "");
    endtask

    task automatic check_rx(input string req);
        chk(got_n == exp_n - 1, req, "pair count", 64'(got_n), 64'(exp_n - 1));
        for (int i = seen; i < got_n; i++) begin
            chk(got_l[i] == exp_l[i], req, "rx left", 64'(got_l[i]), 64'(exp_l[i]));
            chk(got_r[i] == exp_r[i], req, "rx right", 64'(got_r[i]), 64'(exp_r[i]));
        end
        seen = got_n;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_valid == 1'b0, "R1", "reset rx_valid", 64'(rx_valid), 0);
        chk(frame_err == 1'b0, "R1", "reset frame_err", 64'(frame_err), 0);
        chk(tx_load == 1'b0, "R1", "reset tx_load", 64'(tx_load), 0);
        chk(sd_out == 1'b0, "R1", "reset sd_out", 64'(sd_out), 0);
    endtask

    // default format is I2S (R1): full words, junk in unused slots (R2, R3)
    task automatic t_i2s();
        int l0;
        l0 = loads;
        write_tx(24'hA5C3F1, 24'h1E2D3C);
        send_frame(24'h5A0F33, 24'hC3000F, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, "R6");
        write_tx(24'h800001, 24'h7FFFFE);
        send_frame(24'h800001, 24'h7FFF00, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, "R6");
        flush();
        check_rx("R2 R3 R5");
        chk(loads - l0 == 2, "R8", "load pulses", 64'(loads - l0), 2);
    endtask

    // right-justified lengths, both directions follow the shared setting (R10)
    task automatic t_rj(input logic [1:0] f, input logic [23:0] l, input logic [23:0] r);
        set_fmt(f);
        write_tx(l, r);
        send_frame(l, r, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, "R7 R10");
        write_tx(r, l);
        send_frame(r, l, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, "R7 R10");
        flush();
        check_rx("R4 R10");
    endtask

    // no new write: pair repeats, no load strobe (R8)
    task automatic t_repeat();
        int l0;
        l0 = loads;
        send_frame(24'h123456, 24'hFEDCBA, 32'h0, 1'b0, 1'b1, 1'b1, "R8");
        chk(loads == l0, "R8", "no load without write", 64'(loads), 64'(l0));
        flush();
        check_rx("R8");
    endtask

    // word select moved onto a rising edge (R9)
    task automatic t_err();
        set_fmt(2'd0);
        chk(frame_err == 1'b0, "R9", "flag before fault", 64'(frame_err), 0);
        send_frame(24'h111111, 24'h222222, 32'h0, 1'b1, 1'b0, 1'b0, "");
        chk(frame_err == 1'b1, "R9", "flag after fault", 64'(frame_err), 1);
        send_frame(24'h333300, 24'h444400, 32'h0, 1'b0, 1'b1, 1'b0, "");
        flush();
        check_rx("R9");
        chk(frame_err == 1'b1, "R9", "flag sticky", 64'(frame_err), 1);
    endtask

    initial begin
        t_reset();
        t_i2s();
        t_rj(2'd1, 24'h8F3100, 24'h12AB00);
        t_rj(2'd2, 24'hF0E1D0, 24'h0A5C30);
        t_rj(2'd3, 24'h3C5A96, 24'hC0FFEE);
        t_repeat();
        t_err();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule